// File: doc/BRIEF.md
# Lane-wise Floating-Point Magnitude Greater-Than Unit

The unit takes two 128-bit operand vectors and a format selection. It compares them lane by lane on magnitude, so the sign bits are ignored. Each lane of the result is all ones when the first operand's element has a strictly larger magnitude than the second operand's element. Otherwise the lane is all zeros. Lanes can be 16-bit half, 32-bit single or 64-bit double precision. The operation can run over a 64-bit or a 128-bit vector, or on a single scalar element. In scalar form, the result bits above the element are either zeroed or copied from the second operand.

A NaN in any active lane raises an invalid-operation indication, because this is a signaling compare. The indication is reported in one of two ways, chosen by a per-operation control bit:
- as a trap request that travels with the result, or
- by setting a sticky status flag.

The format that combines 64-bit elements with a 64-bit vector is reserved. It is reported as illegal and produces no result.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from the next cycle. The result is held unchanged until it is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a new operation can be accepted in the cycle its predecessor leaves. The reset is asynchronous and active low.

Top module: `fp_absgt_lanes`

## Requirements
- R1: A lane's result is all ones when |A| > |B| and all zeros otherwise; equal magnitudes give zeros.
- R2: The sign bit is ignored: -0 and +0 compare equal, and a negative element compares by its magnitude.
- R3: `in_half`=1 selects 16-bit lanes (exponent 5 bits, mantissa 10 bits). With `in_half`=0, `in_dbl`=0 selects 32-bit lanes (8/23) and `in_dbl`=1 selects 64-bit lanes (11/52). Lane k occupies bits [k*size +: size].
- R4: In vector form, `in_wide`=1 operates on all 128 bits. `in_wide`=0 operates on bits [63:0] and forces result bits [127:64] to zero.
- R5: Vector form with `in_half`=0, `in_dbl`=1 and `in_wide`=0 is reserved. It raises `out_illegal`, the mask is all zeros, `out_invalid` and `out_trap_req` stay low, and the sticky flag is unchanged.
- R6: `in_scalar`=1 operates on lane 0 only, with data width equal to the element size; `in_wide` is ignored. With `in_merge`=0, all higher result bits are zero.
- R7: With `in_scalar`=1 and `in_merge`=1, the result bits above the element are copied from operand B.
- R8: A NaN (all-ones exponent, non-zero mantissa) in either element gives a zero lane and raises `out_invalid`. Infinity is greater than every finite value.
- R9: Only active lanes, those inside the data width, contribute to `out_invalid`.
- R10: When `out_invalid` is high, `in_trap_en`=1 raises `out_trap_req` and leaves the sticky flag unchanged. `in_trap_en`=0 keeps `out_trap_req` low and sets `status_inv_sticky`, which stays set until reset.
- R11: A result appears one cycle after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low. After reset `out_valid`=0, `in_ready`=1 and the sticky flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_opa | input | 128 | Operand A vector |
| in_opb | input | 128 | Operand B vector (also the source of merged bits) |
| in_half | input | 1 | Half-precision lanes |
| in_dbl | input | 1 | Double precision when not half |
| in_wide | input | 1 | 128-bit vector when set, 64-bit when clear |
| in_scalar | input | 1 | Scalar form, lane 0 only |
| in_merge | input | 1 | Scalar upper bits taken from operand B |
| in_trap_en | input | 1 | Report invalid as a trap request instead of the sticky flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_mask | output | 128 | Lane mask result |
| out_invalid | output | 1 | NaN seen in an active lane |
| out_trap_req | output | 1 | Invalid reported as a trap |
| out_illegal | output | 1 | Reserved format requested |
| status_inv_sticky | output | 1 | Sticky invalid status flag |

## Verification
The two functions that can fall in the same cycle are the release of a held, back-pressured result and the acceptance of the next operation. The bench stalls one result for several cycles and checks that the result and the handshake signals stay fixed. It then raises `out_ready` and `in_valid` together, and expects the next result to be the new operation's mask with nothing lost or repeated. A second coincidence is a NaN placed in a lane that the selected format leaves inactive: it is judged by `out_invalid` staying low while the active lanes still produce correct masks.

// File: rtl/fp_absgt_pkg.sv
package fp_absgt_pkg;
  localparam int VEC_W   = 128;
  localparam int N_FMT   = 3;
  localparam int FMT_H   = 0;
  localparam int FMT_S   = 1;
  localparam int FMT_D   = 2;

  function automatic int fmt_exp_w(int f);
    return (f == FMT_H) ? 5 : (f == FMT_S) ? 8 : 11;
  endfunction

  function automatic int fmt_man_w(int f);
    return (f == FMT_H) ? 10 : (f == FMT_S) ? 23 : 52;
  endfunction

  typedef struct packed {
    logic half;
    logic dbl;
    logic wide;
    logic scalar;
    logic merge;
  } absgt_mode_t;
endpackage

// File: rtl/fp_absgt_lane.sv
module fp_absgt_lane #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int LW = EXP_W + MAN_W + 1
) (
  input  logic [LW-1:0] elem_a,
  input  logic [LW-1:0] elem_b,
  output logic          greater,
  output logic          nan_seen
);
  logic [LW-2:0] mag_a, mag_b;
  logic          nan_a, nan_b;

  // sign stripped: the remaining bits order like an unsigned integer
  assign mag_a = elem_a[LW-2:0];
  assign mag_b = elem_b[LW-2:0];

  assign nan_a = (&mag_a[LW-2:MAN_W]) && (|mag_a[MAN_W-1:0]);
  assign nan_b = (&mag_b[LW-2:MAN_W]) && (|mag_b[MAN_W-1:0]);

  assign nan_seen = nan_a | nan_b;
  assign greater  = !nan_seen && (mag_a > mag_b);
endmodule

// File: rtl/fp_absgt_core.sv
module fp_absgt_core
  import fp_absgt_pkg::*;
#(
  parameter int W = VEC_W,
  localparam int DW_BITS = $clog2(W) + 1,
  localparam int NL_BITS = $clog2(W / 16) + 1
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  absgt_mode_t   mode,
  output logic [W-1:0]  mask,
  output logic          invalid,
  output logic          illegal
);
  logic [W-1:0]       fmt_mask [N_FMT];
  logic [N_FMT-1:0]   fmt_inv;
  logic [1:0]         fsel;
  logic [DW_BITS-1:0] data_w;
  logic [NL_BITS-1:0] n_lanes;
  logic [W-1:0]       below;

  always_comb begin
    fsel    = mode.half ? 2'(FMT_H) : (mode.dbl ? 2'(FMT_D) : 2'(FMT_S));
    illegal = !mode.half && mode.dbl && !mode.wide && !mode.scalar;
    n_lanes = '0;
    data_w  = '0;
    case (fsel)
      2'(FMT_H): begin
        n_lanes = mode.scalar ? NL_BITS'(1) : (mode.wide ? NL_BITS'(W/16) : NL_BITS'(W/32));
        data_w  = mode.scalar ? DW_BITS'(16) : (mode.wide ? DW_BITS'(W) : DW_BITS'(W/2));
      end
      2'(FMT_S): begin
        n_lanes = mode.scalar ? NL_BITS'(1) : (mode.wide ? NL_BITS'(W/32) : NL_BITS'(W/64));
        data_w  = mode.scalar ? DW_BITS'(32) : (mode.wide ? DW_BITS'(W) : DW_BITS'(W/2));
      end
      default: begin
        n_lanes = mode.scalar ? NL_BITS'(1) : (mode.wide ? NL_BITS'(W/64) : NL_BITS'(0));
        data_w  = mode.scalar ? DW_BITS'(64) : (mode.wide ? DW_BITS'(W) : DW_BITS'(0));
      end
    endcase
  end

  for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
    localparam int EW = fmt_exp_w(f);
    localparam int MW = fmt_man_w(f);
    localparam int LW = EW + MW + 1;
    localparam int NL = W / LW;
    logic [NL-1:0] lane_inv;
    logic [NL-1:0] lane_act;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic gt;
      fp_absgt_lane #(.EXP_W(EW), .MAN_W(MW)) u_lane (
        .elem_a  (opa[i*LW +: LW]),
        .elem_b  (opb[i*LW +: LW]),
        .greater (gt),
        .nan_seen(lane_inv[i])
      );
      assign fmt_mask[f][i*LW +: LW] = {LW{gt}};
      assign lane_act[i] = NL_BITS'(i) < n_lanes;
    end
    assign fmt_inv[f] = |(lane_inv & lane_act);
  end

  for (genvar k = 0; k < W; k++) begin : g_below
    assign below[k] = DW_BITS'(k) < data_w;
  end

  always_comb begin
    if (illegal) begin
      mask    = '0;
      invalid = 1'b0;
    end else begin
      mask    = (fmt_mask[fsel] & below) |
                ((mode.scalar && mode.merge) ? (opb & ~below) : '0);
      invalid = fmt_inv[fsel];
    end
  end
endmodule

// File: rtl/fp_absgt_lanes.sv
module fp_absgt_lanes
  import fp_absgt_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_opa,
  input  logic [W-1:0] in_opb,
  input  logic         in_half,
  input  logic         in_dbl,
  input  logic         in_wide,
  input  logic         in_scalar,
  input  logic         in_merge,
  input  logic         in_trap_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_mask,
  output logic         out_invalid,
  output logic         out_trap_req,
  output logic         out_illegal,
  output logic         status_inv_sticky
);
  absgt_mode_t  mode;
  logic [W-1:0] c_mask;
  logic         c_inv, c_ill, accept;

  assign mode = '{half: in_half, dbl: in_dbl, wide: in_wide,
                  scalar: in_scalar, merge: in_merge};

  fp_absgt_core #(.W(W)) u_core (
    .opa    (in_opa),
    .opb    (in_opb),
    .mode   (mode),
    .mask   (c_mask),
    .invalid(c_inv),
    .illegal(c_ill)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_mask          <= '0;
      out_invalid       <= 1'b0;
      out_trap_req      <= 1'b0;
      out_illegal       <= 1'b0;
      status_inv_sticky <= 1'b0;
    end else if (accept) begin
      out_valid         <= 1'b1;
      out_mask          <= c_mask;
      out_invalid       <= c_inv;
      out_trap_req      <= c_inv && in_trap_en;
      out_illegal       <= c_ill;
      status_inv_sticky <= status_inv_sticky || (c_inv && !in_trap_en);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) &&
                               $stable(out_invalid) && $stable(out_illegal));
  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_mask == '0 && !out_invalid && !out_trap_req);
  a_r10_trap_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap_req |-> out_invalid);
  a_r10_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_inv_sticky) |-> $past(in_valid && in_ready && !in_trap_en));
endmodule

// File: tb/fp_absgt_lanes_tb_top.sv
module fp_absgt_lanes_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [127:0] in_opa = '0, in_opb = '0;
  logic         in_half = 0, in_dbl = 0, in_wide = 0, in_scalar = 0, in_merge = 0, in_trap_en = 0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] out_mask;
  logic         out_invalid, out_trap_req, out_illegal, status_inv_sticky;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  fp_absgt_lanes dut_i (.*);

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(logic [127:0] a, logic [127:0] b, logic h, logic d, logic w,
                    logic s, logic m, logic t);
    @(negedge clk);
    in_opa = a; in_opb = b; in_half = h; in_dbl = d; in_wide = w;
    in_scalar = s; in_merge = m; in_trap_en = t; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid one cycle after accept", 128'(out_valid), 128'(1));
  endtask

  task automatic t_reset;
    chk("R11 reset out_valid", 128'(out_valid), 128'(0));
    chk("R11 reset in_ready", 128'(in_ready), 128'(1));
    chk("R10 reset sticky", 128'(status_inv_sticky), 128'(0));
  endtask

  task automatic t_half_wide;
    op(128'h0000_0001_7C00_8000_3C00_C200_3C00_4000,
       128'h0001_0000_7BFF_0000_3C00_4000_4000_BC00, 1, 0, 1, 0, 0, 0);
    chk("R1 R2 R3 R8 half lanes", out_mask, 128'h0000_FFFF_FFFF_0000_0000_FFFF_0000_FFFF);
    chk("R1 half invalid low", 128'(out_invalid), 128'(0));
  endtask

  task automatic t_half_narrow_nan_hidden;
    op({16'h7E00, {7{16'h4000}}}, {8{16'h3C00}}, 1, 0, 0, 0, 0, 0);
    chk("R4 half 64-bit mask", out_mask, {64'h0, {4{16'hFFFF}}});
    chk("R9 inactive NaN no flag", 128'(out_invalid), 128'(0));
  endtask

  task automatic t_nan_trap;
    op({{7{16'h4000}}, 16'h7E00}, {8{16'h3C00}}, 1, 0, 1, 0, 0, 1);
    chk("R8 NaN lane zero", out_mask, {{7{16'hFFFF}}, 16'h0000});
    chk("R8 NaN invalid", 128'(out_invalid), 128'(1));
    chk("R10 trap request", 128'(out_trap_req), 128'(1));
    chk("R10 sticky untouched on trap", 128'(status_inv_sticky), 128'(0));
  endtask

  task automatic t_single_narrow;
    op({64'h7FC00000_7FC00000, 32'h3F800000, 32'h40000000},
       {64'h0, 32'hC0000000, 32'h3F800000}, 0, 0, 0, 0, 0, 0);
    chk("R3 R4 single 64-bit", out_mask, {64'h0, 32'h0, 32'hFFFFFFFF});
    chk("R9 single upper NaN ignored", 128'(out_invalid), 128'(0));
  endtask

  task automatic t_double_wide;
    op({64'h3FF0000000000000, 64'hC010000000000000},
       {64'h7FF0000000000000, 64'h4000000000000000}, 0, 1, 1, 0, 0, 0);
    chk("R3 R8 double inf", out_mask, {64'h0, 64'hFFFFFFFFFFFFFFFF});
  endtask

  task automatic t_reserved;
    op({2{64'h7FF8000000000000}}, {2{64'h0}}, 0, 1, 0, 0, 0, 0);
    chk("R5 illegal flag", 128'(out_illegal), 128'(1));
    chk("R5 mask zero", out_mask, 128'h0);
    chk("R5 no invalid", 128'(out_invalid), 128'(0));
    chk("R5 sticky unchanged", 128'(status_inv_sticky), 128'(0));
  endtask

  task automatic t_scalar;
    op({96'h7FC00000_0000_0000_0000_0000, 32'h40000000},
       {96'hDEADBEEF_01234567_89ABCDEF, 32'h3F800000}, 0, 0, 1, 1, 0, 0);
    chk("R6 scalar single no merge", out_mask, {96'h0, 32'hFFFFFFFF});
    chk("R6 scalar lane-0 only flag", 128'(out_invalid), 128'(0));
    op({64'h0, 64'h4000000000000000}, {64'h1111, 64'h3FF0000000000000}, 0, 1, 0, 1, 0, 0);
    chk("R6 scalar double not reserved", 128'(out_illegal), 128'(0));
    chk("R6 scalar double mask", out_mask, {64'h0, 64'hFFFFFFFFFFFFFFFF});
    op({112'h0, 16'h4000}, {112'hCAFE_F00D_1234_5678_9ABC_DEF0_0F0F, 16'h3C00}, 1, 0, 1, 1, 1, 0);
    chk("R7 scalar half merge", out_mask, {112'hCAFE_F00D_1234_5678_9ABC_DEF0_0F0F, 16'hFFFF});
    op({96'h0, 32'h3F800000}, {96'hA5A5A5A5_5A5A5A5A_FFFF0000, 32'h40000000}, 0, 0, 0, 1, 1, 0);
    chk("R7 scalar single merge false", out_mask, {96'hA5A5A5A5_5A5A5A5A_FFFF0000, 32'h0});
  endtask

  task automatic t_sticky;
    op({2{64'h7FF8000000000001}}, {2{64'h0}}, 0, 1, 1, 0, 0, 0);
    chk("R10 no trap when disabled", 128'(out_trap_req), 128'(0));
    chk("R10 sticky set", 128'(status_inv_sticky), 128'(1));
    op({2{64'h4000000000000000}}, {2{64'h0}}, 0, 1, 1, 0, 0, 0);
    chk("R10 sticky stays", 128'(status_inv_sticky), 128'(1));
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_opa = {4{32'h40000000}}; in_opb = {4{32'h3F800000}};
    in_half = 0; in_dbl = 0; in_wide = 1; in_scalar = 0; in_merge = 0; in_trap_en = 0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R11 held valid", 128'(out_valid), 128'(1));
      chk("R11 stalled in_ready low", 128'(in_ready), 128'(0));
      chk("R11 held mask", out_mask, {128{1'b1}});
      @(negedge clk);
    end
    in_opa = {4{32'h3F800000}}; in_opb = {4{32'h40000000}};
    in_valid = 1'b1; out_ready = 1'b1;
    #0 chk("R11 ready on release", 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next result valid", 128'(out_valid), 128'(1));
    chk("R1 R11 next result mask", out_mask, 128'h0);
    @(negedge clk);
    chk("R11 drained", 128'(out_valid), 128'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_half_wide;
    t_half_narrow_nan_hidden;
    t_nan_trap;
    t_single_narrow;
    t_double_wide;
    t_reserved;
    t_scalar;
    t_sticky;
    t_backpressure;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule